// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counter driven by a programmable clock divider, configured through a small register port. Software writes a period value, a divisor split into a low and a high byte, and a control word. While running, the divider produces one tick every divisor+1 clocks. Each tick lowers the counter by one, and a tick that finds the counter at zero reloads it from the period. That same reload sets a sticky event flag, which drives the interrupt line when enabled.

The period is a plain stored value, typically the clock rate in MHz multiplied by the wanted interval in microseconds. A control write can restart the count from the programmed values. A debug-halt input freezes the timer in one of three ways chosen in the control word: it may keep running, stop at once, or run down to zero and hold there.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, period and counter read 0xFFFFFFFF, both divisor bytes and the divider count read 0, the control word reads 0x01 (stopped), and irq_o is low.
- R2: The divisor is {high byte, low byte}. While running, the counter drops by exactly one every divisor+1 clocks, and every clock when the divisor is 0.
- R3: Control bit 0 (stop) set to 1 freezes both the counter and the divider count. Clearing it resumes counting from the frozen values.
- R4: Writing control with bit 1 (restart) set loads the counter from the period and the divider count from the divisor at that clock edge, taking priority over a tick. Bit 1 always reads 0.
- R5: A tick that finds the counter at 0 reloads it from the period and sets the flag (control bit 3).
- R6: The flag stays set until a control write with bit 3 = 1. Writing 0 to bit 3 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: irq_o is high exactly when the flag is set and control bit 2 (interrupt enable) is 1.
- R8: With control bit 5 (free) = 1, halt_i has no effect on counting.
- R9: With free = 0 and soft (control bit 4) = 0, an asserted halt_i freezes the counter and the divider from the next edge.
- R10: With free = 0 and soft = 1, an asserted halt_i lets the counter run down to 0 and hold there with the flag unset. Counting resumes, with reload and flag, once halt_i drops.
- R11: A period write does not change the running counter; the new value takes effect at the next reload.
- R12: Word addresses are: 0 period, 1 counter (read-only), 2 control, 3 divisor low byte, 4 divisor high byte, 5 divider count (read-only). Any other address reads 0, and writes to read-only addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Timer interrupt |

## Verification
Directed runs with a divisor of 2 separate a correct divider from one that is off by one. Runs with a divisor of 0 exercise back-to-back ticks and reload at zero. Stop, restart, and period writes are issued at known counter values, so a restart that is ignored or a period write that leaks into the counter shows up as a wrong count. The three halt modes are each run with halt_i held, which separates immediate freeze, run-to-zero, and free running. A random phase then mixes short periods, small divisors, control words, writes to read-only addresses, and halt toggles. This phase compares every cycle against a bench model, catching flag set/clear collisions and restart-versus-tick priority.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 3'd0,
    A_COUNT  = 3'd1,
    A_CTRL   = 3'd2,
    A_DIV_LO = 3'd3,
    A_DIV_HI = 3'd4,
    A_PSC    = 3'd5
  } reg_addr_e;

  localparam int B_STOP   = 0;
  localparam int B_RELOAD = 1;
  localparam int B_IEN    = 2;
  localparam int B_FLAG   = 3;
  localparam int B_SOFT   = 4;
  localparam int B_FREE   = 5;
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             load_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] psc_o
);
  logic [DIV_W-1:0] psc_q;

  assign tick_o = run_i && (psc_q == '0);
  assign psc_o  = psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
    end else if (load_i) begin
      psc_q <= div_i;
    end else if (run_i) begin
      psc_q <= (psc_q == '0) ? div_i : psc_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  assign zero_evt_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (load_i) begin
      cnt_q <= period_i;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == '0) ? period_i : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DIV_W-1:0]  psc_i,
  input  logic              zero_evt_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              stop_o,
  output logic              ien_o,
  output logic              soft_o,
  output logic              free_o,
  output logic              flag_o,
  output logic              reload_o,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int unsigned HALF_W = DIV_W / 2;

  logic [CNT_W-1:0]  period_q;
  logic [HALF_W-1:0] div_lo_q, div_hi_q;
  logic              stop_q, ien_q, soft_q, free_q, flag_q;
  logic              ctrl_wr;

  assign ctrl_wr  = we_i && (addr_i == A_CTRL);
  assign reload_o = ctrl_wr && wdata_i[B_RELOAD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      div_lo_q <= '0;
      div_hi_q <= '0;
      stop_q   <= 1'b1;
      ien_q    <= 1'b0;
      soft_q   <= 1'b0;
      free_q   <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_PERIOD: period_q <= wdata_i;
        A_DIV_LO: div_lo_q <= wdata_i[HALF_W-1:0];
        A_DIV_HI: div_hi_q <= wdata_i[HALF_W-1:0];
        A_CTRL: begin
          stop_q <= wdata_i[B_STOP];
          ien_q  <= wdata_i[B_IEN];
          soft_q <= wdata_i[B_SOFT];
          free_q <= wdata_i[B_FREE];
        end
        default: ;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           flag_q <= 1'b0;
    else if (zero_evt_i)                   flag_q <= 1'b1;
    else if (ctrl_wr && wdata_i[B_FLAG])   flag_q <= 1'b0;
  end

  always_comb begin
    case (addr_i)
      A_PERIOD: rdata_o = period_q;
      A_COUNT:  rdata_o = cnt_i;
      A_CTRL:   rdata_o = CNT_W'({free_q, soft_q, flag_q, ien_q, 1'b0, stop_q});
      A_DIV_LO: rdata_o = CNT_W'(div_lo_q);
      A_DIV_HI: rdata_o = CNT_W'(div_hi_q);
      A_PSC:    rdata_o = CNT_W'(psc_i);
      default:  rdata_o = '0;
    endcase
  end

  assign period_o = period_q;
  assign div_o    = {div_hi_q, div_lo_q};
  assign stop_o   = stop_q;
  assign ien_o    = ien_q;
  assign soft_o   = soft_q;
  assign free_o   = free_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              halt_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] period_q, cnt_q;
  logic [DIV_W-1:0] div_q, psc_q;
  logic             stop_q, ien_q, soft_q, free_q, flag_q;
  logic             reload_stb, zero_evt, psc_tick, halt_freeze, run;

  // soft mode lets the count reach zero before holding
  assign halt_freeze = halt_i && !free_q && (!soft_q || (cnt_q == '0));
  assign run         = !stop_q && !halt_freeze;
  assign irq_o       = flag_q && ien_q;

  tdt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .psc_i      (psc_q),
    .zero_evt_i (zero_evt),
    .period_o   (period_q),
    .div_o      (div_q),
    .stop_o     (stop_q),
    .ien_o      (ien_q),
    .soft_o     (soft_q),
    .free_o     (free_q),
    .flag_o     (flag_q),
    .reload_o   (reload_stb),
    .rdata_o    (rdata_o)
  );

  tdt_prescaler #(.DIV_W(DIV_W)) i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .run_i  (run),
    .load_i (reload_stb),
    .tick_o (psc_tick),
    .psc_o  (psc_q)
  );

  tdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .period_i   (period_q),
    .tick_i     (psc_tick),
    .load_i     (reload_stb),
    .cnt_o      (cnt_q),
    .zero_evt_o (zero_evt)
  );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  rdata_o,
  input logic              halt_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period_q,
  input logic              psc_tick,
  input logic              reload_stb,
  input logic              stop_q,
  input logic              ien_q,
  input logic              soft_q,
  input logic              free_q,
  input logic              flag_q
);
  logic flag_wr1;
  assign flag_wr1 = we_i && (addr_i == A_CTRL) && wdata_i[B_FLAG];

  p_tick_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_tick && (cnt_q != '0) && !reload_stb |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_stop_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !reload_stb |=> $stable(cnt_q));

  p_restart_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_stb |=> cnt_q == $past(period_q));

  p_restart_reads0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_CTRL |-> !rdata_o[B_RELOAD]);

  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_tick && (cnt_q == '0) && !reload_stb |=> flag_q && cnt_q == $past(period_q));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_wr1 |=> flag_q);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_q && flag_q);

  p_halt_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !free_q && !soft_q && !reload_stb |=> $stable(cnt_q));

  p_soft_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !free_q && soft_q && (cnt_q == '0) && !reload_stb |=> cnt_q == '0);
endmodule

bind prescaled_down_timer tdt_checker #(.CNT_W(CNT_W)) i_tdt_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .halt_i     (halt_i),
  .irq_o      (irq_o),
  .cnt_q      (cnt_q),
  .period_q   (period_q),
  .psc_tick   (psc_tick),
  .reload_stb (reload_stb),
  .stop_q     (stop_q),
  .ien_q      (ien_q),
  .soft_q     (soft_q),
  .free_q     (free_q),
  .flag_q     (flag_q)
);

// File: tb/test_prescaled_down_timer.sv
`timescale 1ns/1ps
module test_prescaled_down_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        halt;
  logic        irq;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  prescaled_down_timer i_prescaled_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .halt_i(halt), .irq_o(irq)
  );

  // reference model of the requirements
  logic [31:0] m_period, m_cnt;
  logic [7:0]  m_lo, m_hi;
  logic [15:0] m_psc;
  logic        m_stop, m_ien, m_soft, m_free, m_flag;

  always @(posedge clk or negedge rst_n) begin
    logic run, tick, ctrl_wr, rl, zevt;
    logic [15:0] div;
    if (!rst_n) begin
      m_period = '1; m_cnt = '1; m_lo = 0; m_hi = 0; m_psc = 0;
      m_stop = 1; m_ien = 0; m_soft = 0; m_free = 0; m_flag = 0;
    end else begin
      div     = {m_hi, m_lo};
      run     = !m_stop && !(halt && !m_free && (!m_soft || m_cnt == 0));
      tick    = run && (m_psc == 0);
      ctrl_wr = we && addr == 3'd2;
      rl      = ctrl_wr && wdata[1];
      zevt    = tick && !rl && m_cnt == 0;
      if (rl) begin m_cnt = m_period; m_psc = div; end
      else begin
        if (tick) m_cnt = (m_cnt == 0) ? m_period : m_cnt - 1;
        if (run)  m_psc = (m_psc == 0) ? div : m_psc - 1;
      end
      if (zevt) m_flag = 1;
      else if (ctrl_wr && wdata[3]) m_flag = 0;
      if (we) case (addr)
        3'd0: m_period = wdata;
        3'd2: begin m_stop = wdata[0]; m_ien = wdata[2]; m_soft = wdata[4]; m_free = wdata[5]; end
        3'd3: m_lo = wdata[7:0];
        3'd4: m_hi = wdata[7:0];
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_period;
      3'd1: return m_cnt;
      3'd2: return {26'b0, m_free, m_soft, m_flag, m_ien, 1'b0, m_stop};
      3'd3: return {24'b0, m_lo};
      3'd4: return {24'b0, m_hi};
      3'd5: return {16'b0, m_psc};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    we = 0; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    we = 0; addr = 3'd1; #1;
    chk("R2 count vs model", rdata, m_cnt);
    chk("R7 irq vs model", {31'b0, irq}, {31'b0, m_flag & m_ien});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; we = 1; wdata = d;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; addr = 0; we = 0; wdata = 0; halt = 0;
    repeat (3) @(negedge clk);
    rd(3'd0, 32'hFFFF_FFFF, "R1 period");
    rd(3'd1, 32'hFFFF_FFFF, "R1 count");
    rd(3'd2, 32'h1, "R1 ctrl");
    rd(3'd3, 32'h0, "R1 div lo");
    rd(3'd4, 32'h0, "R1 div hi");
    rd(3'd5, 32'h0, "R1 psc");
    rd(3'd7, 32'h0, "R12 unused");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    step();

    // R2: divisor 2 -> one step per 3 clocks
    wr(3'd0, 100);
    wr(3'd3, 2);
    wr(3'd2, 32'h2);
    repeat (30) step();
    rd(3'd1, 90, "R2 divided count");
    rd(3'd2, 32'h0, "R4 restart bit reads 0");

    // R3: stop freezes counter and divider
    wr(3'd2, 32'h1);
    repeat (10) step();
    rd(3'd1, 90, "R3 stopped count");
    rd(3'd5, 1, "R3 stopped divider");

    // R11: period write leaves count alone
    wr(3'd0, 5);
    rd(3'd1, 90, "R11 count after period write");
    rd(3'd0, 5, "R12 period readback");

    // R4: restart while stopped
    wr(3'd2, 32'h3);
    rd(3'd1, 5, "R4 restart count");
    rd(3'd5, 2, "R4 restart divider");

    // R5/R7: divisor 0, enable interrupt
    wr(3'd3, 0);
    wr(3'd2, 32'h6);
    repeat (5) step();
    rd(3'd1, 0, "R5 reached zero");
    chk("R5 no irq yet", {31'b0, irq}, 0);
    step();
    rd(3'd1, 5, "R5 reload from period");
    chk("R7 irq on flag", {31'b0, irq}, 1);

    // R6: write 0 to flag keeps it, write 1 clears
    wr(3'd2, 32'h4);
    chk("R6 flag kept", {31'b0, irq}, 1);
    wr(3'd2, 32'hD);
    chk("R6 flag cleared", {31'b0, irq}, 0);

    // R7: flag without enable
    wr(3'd2, 32'h2);
    repeat (6) step();
    rd(3'd2, 32'h8, "R7 flag set, enable off");
    chk("R7 irq gated", {31'b0, irq}, 0);
    wr(3'd2, 32'h4);
    chk("R7 irq after enable", {31'b0, irq}, 1);

    // R8: free run ignores halt
    halt = 1;
    wr(3'd2, 32'h22);
    repeat (3) step();
    halt = 1;
    rd(3'd1, 2, "R8 free run under halt");

    // R9: immediate freeze
    wr(3'd2, 32'h2);
    repeat (4) step();
    halt = 1;
    rd(3'd1, 5, "R9 frozen by halt");

    // R10: run to zero then hold
    wr(3'd2, 32'h1A);
    repeat (10) step();
    halt = 1;
    rd(3'd1, 0, "R10 held at zero");
    rd(3'd2, 32'h10, "R10 no flag while held");
    halt = 0;
    step();
    rd(3'd1, 5, "R10 reload after release");
    rd(3'd2, 32'h18, "R10 flag after release");

    // R12: writes to read-only addresses ignored
    wr(3'd1, 32'h1234);
    wr(3'd5, 32'h77);
    rd(3'd1, m_cnt, "R12 count not writable");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] a;
      r = $urandom % 100;
      a = 3'($urandom % 8);
      rd(a, m_read(a), "R12 random readback");
      if (r < 3) halt = ~halt;
      if (r < 14) begin
        logic [2:0] wa;
        logic [31:0] d;
        wa = 3'($urandom % 6);
        case (wa)
          3'd0: d = $urandom % 24;
          3'd3: d = $urandom % 3;
          3'd4: d = (($urandom % 8) == 0) ? 1 : 0;
          3'd2: d = $urandom & 32'h3E;
          default: d = $urandom;
        endcase
        if (wa == 3'd2 && ($urandom % 6) == 0) d[0] = 1'b1;
        wr(wa, d);
      end else begin
        step();
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule